// File: doc/BRIEF.md
# Sign-Magnitude Compare Flag Unit

This unit decides a one-bit condition flag for an audio signal processor. A compare instruction picks an A operand (the wide accumulator or a narrow data register) and a B operand (a narrow data register, the wide product register, or zero). The unit brings both into the accumulator format, takes their magnitudes, and sets the flag by a sign/magnitude rule rather than a plain signed less-than. The flag drives conditional loads (one kind acts when the flag is 1, the other when it is 0) and conditional branches, all of which sit outside this block.

A narrow data word is widened the same way the adder widens it: the word is placed with five copies of its sign bit above it and COEF_W-GUARD zero bits below it. The operands and selects are captured in the cycle the strobe is high, and the result appears two clocks later with a one-cycle `flag_valid` pulse. The strobe is a plain control pin with no back-pressure, and a new compare may be issued every cycle. The flag then holds until the next result lands.

Top module: `cmpflag_unit`

## Requirements
- R1: With `a_sel`=0 operand A is `acc_in` as a signed value; with `a_sel`=1 it is `br_in` widened to {5 copies of bit 47, `br_in`, 23 zero bits}, so that `br_in`=1 equals an accumulator value of 2^23.
- R2: With `b_sel`=0 operand B is `lr_in` widened the same way as in R1, with `b_sel`=1 it is `mr_in`, and with `b_sel`=2 or 3 it is zero.
- R3: When |A| > |B| the flag is 1.
- R4: When |A| < |B| the flag is 0.
- R5: When |A| = |B| the flag equals the sign bit of B: 0 when both are non-negative or when A is negative and B non-negative, 1 when both are negative or when A is non-negative and B negative.
- R6: A compare issued in cycle t (strobe high when clock edge t+1 comes) shows its flag and a one-cycle `flag_valid` pulse in cycle t+2; compares issued in consecutive cycles yield results in consecutive cycles, and `flag_valid` never rises without an issue two cycles earlier.
- R7: The flag keeps its value in every cycle without a new result, and operand or select changes after the issue cycle do not affect that compare's result.
- R8: After reset `flag` and `flag_valid` are both 0.
- R9: The most negative accumulator value (only bit 75 set) has magnitude 2^75, which is larger than every other magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_go | input | 1 | Compare issue strobe |
| a_sel | input | 1 | Operand A source: 0 accumulator, 1 narrow data register |
| b_sel | input | 2 | Operand B source: 0 narrow data register, 1 product register, 2 or 3 zero |
| acc_in | input | 76 | Accumulator value |
| br_in | input | 48 | Narrow A-side data register |
| lr_in | input | 48 | Narrow B-side data register |
| mr_in | input | 76 | Product register |
| flag | output | 1 | Compare flag, held between results |
| flag_valid | output | 1 | One-cycle pulse when a new flag lands |

## Verification
The bench sweeps every select pair against signed operands on a common scale and against fine-grained accumulator values. This reaches all six sign cases of the equal-magnitude rule, where a design that used a signed less-than or ignored the B sign would give the wrong flag. Cross-format cases such as a narrow 1 against a wide 2^23±1 expose a widening placed at the wrong bit position. The most negative accumulator exposes a magnitude that wraps to zero. Scrambled operands after issue and back-to-back strobes expose a design that samples late or drops or delays a result.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;
  typedef enum logic {
    SRC_A_ACC  = 1'b0,
    SRC_A_DATA = 1'b1
  } src_a_e;

  typedef enum logic [1:0] {
    SRC_B_DATA  = 2'b00,
    SRC_B_PROD  = 2'b01,
    SRC_B_ZERO  = 2'b10,
    SRC_B_ZERO2 = 2'b11
  } src_b_e;
endpackage

// File: rtl/cmpflag_widen.sv
module cmpflag_widen #(
  parameter int DATA_W = 48,
  parameter int COEF_W = 28,
  parameter int GUARD  = 5
) (
  input  logic [DATA_W-1:0]        d_in,
  output logic [DATA_W+COEF_W-1:0] w_out
);
  localparam int PAD = COEF_W - GUARD;
  // place word under guard bits of sign, pad fraction with zeros
  assign w_out = {{GUARD{d_in[DATA_W-1]}}, d_in, {PAD{1'b0}}};
endmodule

// File: rtl/cmpflag_opsel.sv
module cmpflag_opsel
  import cmpflag_pkg::*;
#(
  parameter int DATA_W = 48,
  parameter int COEF_W = 28,
  parameter int GUARD  = 5,
  localparam int ACC_W = DATA_W + COEF_W
) (
  input  src_a_e            a_sel,
  input  src_b_e            b_sel,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [DATA_W-1:0] br_in,
  input  logic [DATA_W-1:0] lr_in,
  input  logic [ACC_W-1:0]  mr_in,
  output logic [ACC_W-1:0]  op_a,
  output logic [ACC_W-1:0]  op_b
);
  logic [ACC_W-1:0] br_w, lr_w;

  cmpflag_widen #(.DATA_W(DATA_W), .COEF_W(COEF_W), .GUARD(GUARD)) u_wid_br (
    .d_in(br_in), .w_out(br_w)
  );
  cmpflag_widen #(.DATA_W(DATA_W), .COEF_W(COEF_W), .GUARD(GUARD)) u_wid_lr (
    .d_in(lr_in), .w_out(lr_w)
  );

  always_comb begin
    op_a = (a_sel == SRC_A_DATA) ? br_w : acc_in;
    unique case (b_sel)
      SRC_B_DATA: op_b = lr_w;
      SRC_B_PROD: op_b = mr_in;
      default:    op_b = '0;
    endcase
  end
endmodule

// File: rtl/cmpflag_magreg.sv
module cmpflag_magreg #(
  parameter int ACC_W = 76,
  localparam int NOPS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [ACC_W-1:0] op_a,
  input  logic [ACC_W-1:0] op_b,
  output logic [ACC_W-1:0] mag_a,
  output logic [ACC_W-1:0] mag_b,
  output logic             sign_b,
  output logic             stage_v
);
  logic [ACC_W-1:0] ops  [NOPS];
  logic [ACC_W-1:0] mags [NOPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_mag
    logic [ACC_W-1:0] abs_c;
    // unsigned magnitude: the most negative value maps to 2^(ACC_W-1)
    assign abs_c = ops[i][ACC_W-1] ? (~ops[i] + 1'b1) : ops[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mags[i] <= '0;
      else if (go) mags[i] <= abs_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_b  <= 1'b0;
      stage_v <= 1'b0;
    end else begin
      stage_v <= go;
      if (go) sign_b <= op_b[ACC_W-1];
    end
  end

  assign mag_a = mags[0];
  assign mag_b = mags[1];
endmodule

// File: rtl/cmpflag_decide.sv
module cmpflag_decide #(
  parameter int ACC_W = 76
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stage_v,
  input  logic [ACC_W-1:0] mag_a,
  input  logic [ACC_W-1:0] mag_b,
  input  logic             sign_b,
  output logic             flag,
  output logic             flag_valid
);
  logic next_flag;

  always_comb begin
    if (mag_a > mag_b)      next_flag = 1'b1;
    else if (mag_a < mag_b) next_flag = 1'b0;
    else                    next_flag = sign_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag       <= 1'b0;
      flag_valid <= 1'b0;
    end else begin
      flag_valid <= stage_v;
      if (stage_v) flag <= next_flag;
    end
  end
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
  import cmpflag_pkg::*;
#(
  parameter int DATA_W = 48,
  parameter int COEF_W = 28,
  parameter int GUARD  = 5,
  localparam int ACC_W = DATA_W + COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_go,
  input  logic              a_sel,
  input  logic [1:0]        b_sel,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [DATA_W-1:0] br_in,
  input  logic [DATA_W-1:0] lr_in,
  input  logic [ACC_W-1:0]  mr_in,
  output logic              flag,
  output logic              flag_valid
);
  logic [ACC_W-1:0] op_a, op_b, mag_a, mag_b;
  logic             sign_b, stage_v;

  cmpflag_opsel #(.DATA_W(DATA_W), .COEF_W(COEF_W), .GUARD(GUARD)) u_opsel (
    .a_sel (src_a_e'(a_sel)),
    .b_sel (src_b_e'(b_sel)),
    .acc_in(acc_in),
    .br_in (br_in),
    .lr_in (lr_in),
    .mr_in (mr_in),
    .op_a  (op_a),
    .op_b  (op_b)
  );

  cmpflag_magreg #(.ACC_W(ACC_W)) u_mag (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (cmp_go),
    .op_a   (op_a),
    .op_b   (op_b),
    .mag_a  (mag_a),
    .mag_b  (mag_b),
    .sign_b (sign_b),
    .stage_v(stage_v)
  );

  cmpflag_decide #(.ACC_W(ACC_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .stage_v   (stage_v),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .sign_b    (sign_b),
    .flag      (flag),
    .flag_valid(flag_valid)
  );
endmodule

// File: rtl/cmpflag_unit_chk.sv
module cmpflag_unit_chk #(
  parameter int DATA_W = 48,
  parameter int ACC_W  = 76
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_go,
  input logic              a_sel,
  input logic [1:0]        b_sel,
  input logic [ACC_W-1:0]  acc_in,
  input logic [DATA_W-1:0] br_in,
  input logic [DATA_W-1:0] lr_in,
  input logic [ACC_W-1:0]  mr_in,
  input logic              flag,
  input logic              flag_valid
);
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |-> ##2 flag_valid);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid |-> $past(cmp_go, 2));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_valid |-> $stable(flag));

  assert_zero_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && $past(b_sel[1], 2) && !$past(a_sel, 2) && ($past(acc_in, 2) != '0))
      |-> flag);

  assert_equal_mag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && !$past(a_sel, 2) && ($past(b_sel, 2) == 2'b01) &&
     ($past(acc_in, 2) == $past(mr_in, 2)))
      |-> (flag == $past(mr_in[ACC_W-1], 2)));
endmodule

bind cmpflag_unit cmpflag_unit_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .a_sel(a_sel), .b_sel(b_sel),
  .acc_in(acc_in), .br_in(br_in), .lr_in(lr_in), .mr_in(mr_in),
  .flag(flag), .flag_valid(flag_valid)
);

// File: tb/sim_cmpflag_unit.sv
`timescale 1ns/1ps
module sim_cmpflag_unit;
  localparam int DW = 48;
  localparam int AW = 76;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_go = 1'b0;
  logic          a_sel = 1'b0;
  logic [1:0]    b_sel = 2'b00;
  logic [AW-1:0] acc_in = '0;
  logic [DW-1:0] br_in = '0;
  logic [DW-1:0] lr_in = '0;
  logic [AW-1:0] mr_in = '0;
  logic          flag, flag_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmpflag_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .a_sel(a_sel), .b_sel(b_sel),
    .acc_in(acc_in), .br_in(br_in), .lr_in(lr_in), .mr_in(mr_in),
    .flag(flag), .flag_valid(flag_valid)
  );

  function automatic bit exp_flag(bit sa, logic [1:0] sb, logic [AW-1:0] ac,
                                  logic [DW-1:0] b, logic [DW-1:0] l, logic [AW-1:0] m);
    logic signed [AW:0] wa, wb, ma, mb;
    wa = sa ? ($signed({{(AW-DW+1){b[DW-1]}}, b}) * 77'sd8388608) : $signed({ac[AW-1], ac});
    if (sb == 2'b00)      wb = $signed({{(AW-DW+1){l[DW-1]}}, l}) * 77'sd8388608;
    else if (sb == 2'b01) wb = $signed({m[AW-1], m});
    else                  wb = '0;
    ma = (wa < 0) ? -wa : wa;
    mb = (wb < 0) ? -wb : wb;
    if (ma > mb) return 1'b1;
    if (ma < mb) return 1'b0;
    return (wb < 0);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // issue at negedge, scramble after issue, check result in cycle t+2 and hold in t+3
  task automatic run_cmp(string tag, bit sa, logic [1:0] sb, logic [AW-1:0] ac,
                         logic [DW-1:0] b, logic [DW-1:0] l, logic [AW-1:0] m);
    bit e;
    e = exp_flag(sa, sb, ac, b, l, m);
    a_sel = sa; b_sel = sb; acc_in = ac; br_in = b; lr_in = l; mr_in = m;
    cmp_go = 1'b1;
    @(negedge clk);
    cmp_go = 1'b0;
    a_sel = ~sa; b_sel = ~sb; acc_in = ~ac; br_in = ~b; lr_in = ~l; mr_in = ~m;
    check({tag, " R6 no early valid"}, flag_valid, 1'b0);
    @(negedge clk);
    check({tag, " R6 valid"}, flag_valid, 1'b1);
    check(tag, flag, e);
    @(negedge clk);
    check({tag, " R7 hold"}, flag, e);
    check({tag, " R6 pulse"}, flag_valid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] big_neg, big_pos;
    big_neg = '0; big_neg[AW-1] = 1'b1;
    big_pos = ~big_neg;

    repeat (3) @(negedge clk);
    check("R8 reset flag", flag, 1'b0);
    check("R8 reset valid", flag_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", flag_valid, 1'b0);

    // sweep: select pairs against signed operands on a common scale (R3 R4 R5 R1 R2)
    for (int sa = 0; sa < 2; sa++)
      for (int sb = 0; sb < 4; sb++)
        for (int x = -3; x <= 3; x++)
          for (int y = -3; y <= 3; y++) begin
            logic signed [AW-1:0] xs, ys;
            xs = AW'(x); ys = AW'(y);
            run_cmp("R3/R4/R5 sweep", sa[0], sb[1:0], xs <<< 23, DW'(x), DW'(y), ys <<< 23);
          end

    // fine-grained accumulator against product register (R3 R4 R5)
    for (int x = -4; x <= 4; x++)
      for (int y = -4; y <= 4; y++)
        run_cmp("R5 fine", 1'b0, 2'b01, AW'(x), '0, '0, AW'(y));

    // R1 widening position: br=1 equals 2^23
    run_cmp("R1 br eq", 1'b1, 2'b01, '0, DW'(1), '0, AW'(76'd8388608));
    run_cmp("R1 br gt", 1'b1, 2'b01, '0, DW'(1), '0, AW'(76'd8388607));
    run_cmp("R1 br lt", 1'b1, 2'b01, '0, DW'(1), '0, AW'(76'd8388609));
    run_cmp("R2 lr widen", 1'b0, 2'b00, AW'(76'd8388609), '0, DW'(1), '0);
    run_cmp("R2 zero alt", 1'b0, 2'b11, AW'(1), '0, DW'(5), AW'(9));
    run_cmp("R2 zero eq", 1'b0, 2'b10, '0, '0, DW'(5), AW'(9));
    // R9 most negative accumulator
    run_cmp("R9 min vs max", 1'b0, 2'b01, big_neg, '0, '0, big_pos);
    run_cmp("R9 min vs min", 1'b0, 2'b01, big_neg, '0, '0, big_neg);
    run_cmp("R9 max vs min", 1'b0, 2'b01, big_pos, '0, '0, big_neg);

    // R6 back-to-back: three strobes in consecutive cycles
    a_sel = 1'b0; b_sel = 2'b01;
    acc_in = AW'(5); mr_in = AW'(3); cmp_go = 1'b1;          // expect 1
    @(negedge clk);
    acc_in = AW'(2); mr_in = AW'(3);                          // expect 0
    @(negedge clk);
    check("R6 b2b first", flag, 1'b1);
    check("R6 b2b first valid", flag_valid, 1'b1);
    acc_in = AW'(3); mr_in = -AW'(3);                          // expect 1
    @(negedge clk);
    cmp_go = 1'b0;
    check("R6 b2b second", flag, 1'b0);
    check("R6 b2b second valid", flag_valid, 1'b1);
    @(negedge clk);
    check("R6 b2b third", flag, 1'b1);
    check("R6 b2b third valid", flag_valid, 1'b1);
    @(negedge clk);
    check("R6 b2b end", flag_valid, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 long hold", flag, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule